// File: doc/BRIEF.md
# Interrupt Message Dispatcher

This block turns per-source interrupt state into message-signalled interrupts. It looks at a pending/enable view of up to `NSRC` sources, numbered 1 to `NSRC`. When a source is both enabled and pending and the domain-wide enable is set, the block sends one message on a valid/ready output. The message fields come from that source's target word. When the message is accepted, a one-cycle strobe tells the owner of the pending bits to clear the bit for that source.

Every register write sweeps all sources in ascending order. The write may be to a target word, to the generate-message word, or to any other register, which is reported on a strobe input. A change on one source's input line requests an evaluation of that source alone. Software can also send a single message directly by writing the generate-message word. That message goes out whatever the domain enable says, and it takes the output ahead of the sweep.

The target words and the stored generate-message word live inside the block. The bus slave and the logic that senses the source lines live outside it.

Top module: `msi_dispatch`

## Requirements
- R1: After reset the block presents no message (`msg_valid_o` low) and no clear strobe. Every target word and the stored generate-message word read as zero.
- R2: A source is delivered only if the domain enable, its enable bit and its pending bit are all 1. While the domain enable is 0 no source is delivered, and the pending bits stay set. A later sweep with the enable at 1 then delivers them.
- R3: `pend_clr_o[i]` rises for exactly one cycle, only in the cycle in which a message for source i is accepted (`msg_valid_o` and `msg_ready_i` both high). At most one bit of `pend_clr_o` is high at a time.
- R4: A message for source i carries three fields of target word i: hart index from bits 31:18 on `msg_hart_o`, guest index from bits 17:12 on `msg_guest_o`, and identity from bits 10:0 on `msg_id_o`.
- R5: A target write stores the data with bit 11 forced to 0, and all other bits are kept. A write with an index of 0 or above `NSRC` changes no target word.
- R6: Any register write starts a sweep that evaluates sources 1 to `NSRC` in ascending order. The register writes are a pulse on `reg_wr_i`, a target write or a generate-message write. Messages from one sweep therefore leave in ascending source order.
- R7: A pulse on `line_evt_i` with an index from 1 to `NSRC` evaluates that source only, and no other pending source is delivered. An index of 0 is ignored.
- R8: A generate-message write sends exactly one message. Its hart index is data bits 31:18, its guest index is 0 and its identity is data bits 10:0, and it is sent even while the domain enable is 0. `gen_q_o` holds the written data with bits 17:12 cleared.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, the message stays valid with unchanged fields, the sweep does not advance, and no pending bit is cleared.
- R10: When a generate-message request and a sweep candidate both wait for a free output, the generate-message request is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| dom_ie_i | input | 1 | Domain-wide interrupt enable |
| src_en_i | input | NSRC | Enable bit per source; bit i is source i (indices NSRC:1) |
| src_pend_i | input | NSRC | Pending bit per source; bit i is source i |
| reg_wr_i | input | 1 | Pulse for a register write elsewhere; requests a sweep |
| tgt_we_i | input | 1 | Target word write strobe |
| tgt_widx_i | input | IDXW | Source index of the target write |
| tgt_wdata_i | input | 32 | Target write data |
| tgt_ridx_i | input | IDXW | Source index for target readback |
| tgt_rdata_o | output | 32 | Target word at `tgt_ridx_i`; zero for an index out of range |
| gen_we_i | input | 1 | Generate-message write strobe |
| gen_wdata_i | input | 32 | Generate-message write data |
| gen_q_o | output | 32 | Stored generate-message word |
| line_evt_i | input | 1 | Pulse when one source's line input changed |
| line_idx_i | input | IDXW | Source whose line changed |
| pend_clr_o | output | NSRC | One-cycle clear strobe per source (indices NSRC:1) |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| msg_hart_o | output | 14 | Hart index of the message |
| msg_guest_o | output | 6 | Guest index of the message |
| msg_id_o | output | 11 | Interrupt identity of the message |

## Verification
Most internal faults in this block show up at the message port within one sweep, so within a few cycles per source. A sweep pointer that skips or repeats a source shows up as a missing, doubled or out-of-order identity. A lost or misdirected clear strobe leaves a pending bit set that the next sweep delivers again. A faulty enable gate sends messages while the domain enable is low. A faulty stall path lets the fields change before acceptance, or clears a pending bit on a message that was never accepted. The stored target and generate-message words can be read at the ports, so masking faults show up in the cycle after the write.

// File: rtl/disp_pkg.sv
// Shared types for the interrupt message dispatcher.
// Assumes a fixed 32-bit target word with hart, guest and identity fields.
package disp_pkg;
    localparam int HART_W    = 14;
    localparam int GUEST_W   = 6;
    localparam int ID_W      = 11;
    localparam int HART_LSB  = 18;
    localparam int GUEST_LSB = 12;
    // bits kept on a target write: everything except bit 11
    localparam logic [31:0] TGT_KEEP    = 32'hFFFF_F7FF;
    // guest field position inside a 32-bit word
    localparam logic [31:0] GUEST_FIELD = 32'h0003_F000;

    typedef struct packed {
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic [ID_W-1:0]    id;
    } msg_t;

    typedef enum logic [1:0] {SC_IDLE, SC_RUN, SC_WAIT} scan_st_e;

    // Splits a target word into its message fields.
    function automatic msg_t tgt_decode(input logic [31:0] w);
        msg_t m;
        m.hart  = w[HART_LSB +: HART_W];
        m.guest = w[GUEST_LSB +: GUEST_W];
        m.id    = w[ID_W-1:0];
        return m;
    endfunction
endpackage

// File: rtl/disp_tgt_regs.sv
// Target word file: one 32-bit word per source, 1..NSRC.
// Writes drop bit 11; indices outside 1..NSRC match no word.
// Two combinational read ports: one for the sweep, one for software.
module disp_tgt_regs
    import disp_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [31:0]     wdata_i,
    input  logic [IDXW-1:0] sidx_i,
    output logic [31:0]     sdata_o,
    input  logic [IDXW-1:0] ridx_i,
    output logic [31:0]     rdata_o
);
    logic [31:0] tgt_q [1:NSRC];

    for (genvar g = 1; g <= NSRC; g++) begin : g_word
        // Holds one source's target word, masked on write.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                tgt_q[g] <= '0;
            else if (we_i && widx_i == IDXW'(g))
                tgt_q[g] <= wdata_i & TGT_KEEP;
        end
    end

    // Selects the words for the sweep index and the readback index.
    always_comb begin
        sdata_o = '0;
        rdata_o = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (sidx_i == IDXW'(i)) sdata_o = tgt_q[i];
            if (ridx_i == IDXW'(i)) rdata_o = tgt_q[i];
        end
    end
endmodule

// File: rtl/disp_scan.sv
// Sweep engine. Steps a pointer over sources 1..NSRC, one per cycle.
// A full sweep runs for each register write; a single-source evaluation
// runs for a line event. The engine asks for the output while the source
// at the pointer qualifies, waits for the grant, then waits for acceptance.
// Assumes grant_i only in a cycle where cand_req_o is high.
module disp_scan
    import disp_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            dom_ie_i,
    input  logic [NSRC:1]   src_en_i,
    input  logic [NSRC:1]   src_pend_i,
    input  logic            rescan_req_i,
    input  logic            line_evt_i,
    input  logic [IDXW-1:0] line_idx_i,
    input  logic            grant_i,
    input  logic            done_i,
    output logic            cand_req_o,
    output logic [IDXW-1:0] cand_idx_o
);
    scan_st_e        st_q;
    logic [IDXW-1:0] ptr_q;
    logic            single_q;
    logic            rescan_q;
    logic            sgl_q;
    logic [IDXW-1:0] sgl_idx_q;
    logic            en_at, pd_at, hit, last;
    logic            start_full, start_sgl, line_ok;

    // Reads the enable and pending bits at the pointer.
    always_comb begin
        en_at = 1'b0;
        pd_at = 1'b0;
        for (int i = 1; i <= NSRC; i++) begin
            if (ptr_q == IDXW'(i)) begin
                en_at = src_en_i[i];
                pd_at = src_pend_i[i];
            end
        end
    end

    assign hit        = (st_q == SC_RUN) && dom_ie_i && en_at && pd_at;
    assign last       = single_q || (ptr_q == IDXW'(NSRC));
    assign start_full = (st_q == SC_IDLE) && rescan_q;
    assign start_sgl  = (st_q == SC_IDLE) && !rescan_q && sgl_q;
    assign line_ok    = line_evt_i && (line_idx_i != '0) && (line_idx_i <= IDXW'(NSRC));
    assign cand_req_o = hit;
    assign cand_idx_o = ptr_q;

    // Remembers sweep and single-source requests until the engine is free.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rescan_q  <= 1'b0;
            sgl_q     <= 1'b0;
            sgl_idx_q <= '0;
        end else begin
            rescan_q <= rescan_req_i | (rescan_q & ~start_full);
            sgl_q    <= line_ok | (sgl_q & ~start_sgl);
            if (line_ok) sgl_idx_q <= line_idx_i;
        end
    end

    // Moves the pointer and the engine state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q     <= SC_IDLE;
            ptr_q    <= '0;
            single_q <= 1'b0;
        end else begin
            case (st_q)
                SC_IDLE: begin
                    if (start_full) begin
                        st_q     <= SC_RUN;
                        ptr_q    <= IDXW'(1);
                        single_q <= 1'b0;
                    end else if (start_sgl) begin
                        st_q     <= SC_RUN;
                        ptr_q    <= sgl_idx_q;
                        single_q <= 1'b1;
                    end
                end
                SC_RUN: begin
                    if (hit) begin
                        if (grant_i) st_q <= SC_WAIT;
                    end else if (last) begin
                        st_q <= SC_IDLE;
                    end else begin
                        ptr_q <= ptr_q + IDXW'(1);
                    end
                end
                SC_WAIT: begin
                    if (done_i) begin
                        if (last) begin
                            st_q <= SC_IDLE;
                        end else begin
                            st_q  <= SC_RUN;
                            ptr_q <= ptr_q + IDXW'(1);
                        end
                    end
                end
                default: st_q <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/disp_out.sv
// Output slot and generate-message register. Holds one message until it
// is accepted. Loads a new message only when the slot is empty, with the
// generate-message request ahead of the sweep candidate. Drives the
// pending-clear strobe for the source of an accepted sweep message.
module disp_out
    import disp_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int IDXW = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               gen_we_i,
    input  logic [31:0]        gen_wdata_i,
    output logic [31:0]        gen_q_o,
    input  logic               cand_req_i,
    input  logic [IDXW-1:0]    cand_idx_i,
    input  logic [31:0]        cand_tgt_i,
    output logic               grant_o,
    output logic               done_o,
    output logic [NSRC:1]      pend_clr_o,
    output logic               msg_valid_o,
    input  logic               msg_ready_i,
    output logic [HART_W-1:0]  msg_hart_o,
    output logic [GUEST_W-1:0] msg_guest_o,
    output logic [ID_W-1:0]    msg_id_o
);
    logic            gen_req_q;
    msg_t            gen_msg_q;
    logic [31:0]     gen_word_q;
    logic            slot_valid_q;
    msg_t            slot_msg_q;
    logic [IDXW-1:0] slot_src_q;
    logic            fire, load_gen;

    assign fire     = slot_valid_q && msg_ready_i;
    assign load_gen = !slot_valid_q && gen_req_q;
    assign grant_o  = !slot_valid_q && !gen_req_q && cand_req_i;
    assign done_o   = fire && (slot_src_q != '0);

    // Raises the clear strobe of the source whose message is accepted.
    always_comb begin
        pend_clr_o = '0;
        for (int i = 1; i <= NSRC; i++)
            pend_clr_o[i] = fire && (slot_src_q == IDXW'(i));
    end

    // Captures a generate-message write and keeps it until it is loaded.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gen_req_q  <= 1'b0;
            gen_msg_q  <= '0;
            gen_word_q <= '0;
        end else if (gen_we_i) begin
            gen_req_q       <= 1'b1;
            gen_msg_q.hart  <= gen_wdata_i[HART_LSB +: HART_W];
            gen_msg_q.guest <= '0;
            gen_msg_q.id    <= gen_wdata_i[ID_W-1:0];
            gen_word_q      <= gen_wdata_i & ~GUEST_FIELD;
        end else if (load_gen) begin
            gen_req_q <= 1'b0;
        end
    end

    // Fills and empties the single output slot.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_valid_q <= 1'b0;
            slot_msg_q   <= '0;
            slot_src_q   <= '0;
        end else if (fire) begin
            slot_valid_q <= 1'b0;
        end else if (load_gen) begin
            slot_valid_q <= 1'b1;
            slot_msg_q   <= gen_msg_q;
            slot_src_q   <= '0;
        end else if (grant_o) begin
            slot_valid_q <= 1'b1;
            slot_msg_q   <= tgt_decode(cand_tgt_i);
            slot_src_q   <= cand_idx_i;
        end
    end

    assign gen_q_o     = gen_word_q;
    assign msg_valid_o = slot_valid_q;
    assign msg_hart_o  = slot_msg_q.hart;
    assign msg_guest_o = slot_msg_q.guest;
    assign msg_id_o    = slot_msg_q.id;
endmodule

// File: rtl/msi_dispatch.sv
// Interrupt message dispatcher top. Connects the target word file, the
// sweep engine and the output slot. Any register write requests a full
// sweep. Assumes the pending bits are owned outside and are cleared by
// pend_clr_o.
module msi_dispatch
    import disp_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDXW = $clog2(NSRC + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               dom_ie_i,
    input  logic [NSRC:1]      src_en_i,
    input  logic [NSRC:1]      src_pend_i,
    input  logic               reg_wr_i,
    input  logic               tgt_we_i,
    input  logic [IDXW-1:0]    tgt_widx_i,
    input  logic [31:0]        tgt_wdata_i,
    input  logic [IDXW-1:0]    tgt_ridx_i,
    output logic [31:0]        tgt_rdata_o,
    input  logic               gen_we_i,
    input  logic [31:0]        gen_wdata_i,
    output logic [31:0]        gen_q_o,
    input  logic               line_evt_i,
    input  logic [IDXW-1:0]    line_idx_i,
    output logic [NSRC:1]      pend_clr_o,
    output logic               msg_valid_o,
    input  logic               msg_ready_i,
    output logic [HART_W-1:0]  msg_hart_o,
    output logic [GUEST_W-1:0] msg_guest_o,
    output logic [ID_W-1:0]    msg_id_o
);
    logic            rescan_req;
    logic            cand_req, scan_grant, scan_done;
    logic [IDXW-1:0] cand_idx;
    logic [31:0]     cand_tgt;

    assign rescan_req = reg_wr_i | tgt_we_i | gen_we_i;

    disp_tgt_regs #(.NSRC(NSRC), .IDXW(IDXW)) u_tgt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (tgt_we_i),
        .widx_i  (tgt_widx_i),
        .wdata_i (tgt_wdata_i),
        .sidx_i  (cand_idx),
        .sdata_o (cand_tgt),
        .ridx_i  (tgt_ridx_i),
        .rdata_o (tgt_rdata_o)
    );

    disp_scan #(.NSRC(NSRC), .IDXW(IDXW)) u_scan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .dom_ie_i     (dom_ie_i),
        .src_en_i     (src_en_i),
        .src_pend_i   (src_pend_i),
        .rescan_req_i (rescan_req),
        .line_evt_i   (line_evt_i),
        .line_idx_i   (line_idx_i),
        .grant_i      (scan_grant),
        .done_i       (scan_done),
        .cand_req_o   (cand_req),
        .cand_idx_o   (cand_idx)
    );

    disp_out #(.NSRC(NSRC), .IDXW(IDXW)) u_out (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .gen_we_i    (gen_we_i),
        .gen_wdata_i (gen_wdata_i),
        .gen_q_o     (gen_q_o),
        .cand_req_i  (cand_req),
        .cand_idx_i  (cand_idx),
        .cand_tgt_i  (cand_tgt),
        .grant_o     (scan_grant),
        .done_o      (scan_done),
        .pend_clr_o  (pend_clr_o),
        .msg_valid_o (msg_valid_o),
        .msg_ready_i (msg_ready_i),
        .msg_hart_o  (msg_hart_o),
        .msg_guest_o (msg_guest_o),
        .msg_id_o    (msg_id_o)
    );
endmodule

// File: rtl/disp_chk.sv
// Protocol and ordering checks for msi_dispatch, attached by bind.
module disp_chk #(
    parameter int NSRC = 8,
    parameter int IDXW = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            dom_ie_i,
    input logic [NSRC:1]   src_en_i,
    input logic [NSRC:1]   src_pend_i,
    input logic [NSRC:1]   pend_clr_o,
    input logic            msg_valid_o,
    input logic            msg_ready_i,
    input logic [30:0]     msg_fields,
    input logic [5:0]      msg_guest_o,
    input logic            scan_grant,
    input logic            gen_req,
    input logic [IDXW-1:0] slot_src
);
    // R9: a stalled message stays and keeps its fields
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_fields)));

    // R3: at most one clear strobe at a time
    p_clr_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pend_clr_o));

    // R3: a clear strobe only on an accepted message
    p_clr_handshake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_clr_o != '0) |-> (msg_valid_o && msg_ready_i));

    // R2: a sweep grant needs the domain enable and an enabled pending source
    p_ie_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_grant |-> (dom_ie_i && ((src_en_i & src_pend_i) != '0)));

    // R8: a generated message has a zero guest index
    p_gen_guest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && slot_src == '0) |-> (msg_guest_o == '0));

    // R10: a waiting generate request takes a free slot next
    p_gen_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!msg_valid_o && gen_req) |=> (msg_valid_o && slot_src == '0));
endmodule

bind msi_dispatch disp_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dom_ie_i    (dom_ie_i),
    .src_en_i    (src_en_i),
    .src_pend_i  (src_pend_i),
    .pend_clr_o  (pend_clr_o),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_fields  ({msg_hart_o, msg_guest_o, msg_id_o}),
    .msg_guest_o (msg_guest_o),
    .scan_grant  (scan_grant),
    .gen_req     (u_out.gen_req_q),
    .slot_src    (u_out.slot_src_q)
);

// File: tb/sim_msi_dispatch.sv
module sim_msi_dispatch;
    localparam int NSRC = 8;
    localparam int IDXW = $clog2(NSRC + 1);
    localparam int NVEC = 6;
    // {ie, enable mask, pending mask, expected delivered mask}; bit k = source k+1
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'hFF, 8'hA5, 8'hA5},
        {1'b1, 8'h0F, 8'hFF, 8'h0F},
        {1'b0, 8'hFF, 8'hFF, 8'h00},
        {1'b1, 8'h3C, 8'h66, 8'h24},
        {1'b1, 8'h81, 8'h81, 8'h81},
        {1'b1, 8'h00, 8'hFF, 8'h00}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dom_ie = 1'b0;
    logic [NSRC:1]   src_en = '0;
    logic [NSRC:1]   pend;
    logic [NSRC:1]   pend_set = '0;
    logic [NSRC:1]   pend_drop = '0;
    logic            reg_wr = 1'b0;
    logic            tgt_we = 1'b0;
    logic [IDXW-1:0] tgt_widx = '0;
    logic [31:0]     tgt_wdata = '0;
    logic [IDXW-1:0] tgt_ridx = '0;
    logic [31:0]     tgt_rdata;
    logic            gen_we = 1'b0;
    logic [31:0]     gen_wdata = '0;
    logic [31:0]     gen_q;
    logic            line_evt = 1'b0;
    logic [IDXW-1:0] line_idx = '0;
    logic [NSRC:1]   pend_clr;
    logic            msg_valid;
    logic            msg_ready = 1'b1;
    logic [13:0]     msg_hart;
    logic [5:0]      msg_guest;
    logic [10:0]     msg_id;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int log_n = 0;
    logic [13:0] log_hart [64];
    logic [5:0]  log_guest [64];
    logic [10:0] log_id [64];

    always #4 clk = ~clk;

    msi_dispatch #(.NSRC(NSRC)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .dom_ie_i(dom_ie),
        .src_en_i(src_en), .src_pend_i(pend), .reg_wr_i(reg_wr),
        .tgt_we_i(tgt_we), .tgt_widx_i(tgt_widx), .tgt_wdata_i(tgt_wdata),
        .tgt_ridx_i(tgt_ridx), .tgt_rdata_o(tgt_rdata),
        .gen_we_i(gen_we), .gen_wdata_i(gen_wdata), .gen_q_o(gen_q),
        .line_evt_i(line_evt), .line_idx_i(line_idx),
        .pend_clr_o(pend_clr), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
        .msg_hart_o(msg_hart), .msg_guest_o(msg_guest), .msg_id_o(msg_id)
    );

    // pending bits owned by the bench, cleared by the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~pend_clr & ~pend_drop) | pend_set;
    end

    // message log: records every accepted handshake
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready && log_n < 64) begin
            log_hart[log_n]  = msg_hart;
            log_guest[log_n] = msg_guest;
            log_id[log_n]    = msg_id;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pend(input logic [NSRC:1] m);
        @(negedge clk); pend_set = m;
        @(negedge clk); pend_set = '0;
    endtask

    task automatic drop_pend();
        @(negedge clk); pend_drop = '1;
        @(negedge clk); pend_drop = '0;
    endtask

    task automatic pulse_reg_wr();
        @(negedge clk); reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic write_tgt(input int idx, input logic [31:0] d);
        @(negedge clk); tgt_we = 1'b1; tgt_widx = IDXW'(idx); tgt_wdata = d;
        @(negedge clk); tgt_we = 1'b0;
    endtask

    task automatic write_gen(input logic [31:0] d);
        @(negedge clk); gen_we = 1'b1; gen_wdata = d;
        @(negedge clk); gen_we = 1'b0;
    endtask

    task automatic line_pulse(input int idx);
        @(negedge clk); line_evt = 1'b1; line_idx = IDXW'(idx);
        @(negedge clk); line_evt = 1'b0;
    endtask

    function automatic logic [31:0] tgt_word(input int i);
        return {14'(i * 5), 6'(i), 1'b1, 11'(32'h40 + i)};
    endfunction

    function automatic logic [NSRC:1] sb(input int i);
        logic [NSRC:1] m;
        m = '0;
        m[i] = 1'b1;
        return m;
    endfunction

    // checks one logged message against source i's target fields
    task automatic chk_src_msg(input int k, input int i, input string req);
        chk(log_id[k] == 11'(32'h40 + i), req, 32'(log_id[k]), 32'h40 + i);
        chk(log_hart[k] == 14'(i * 5) && log_guest[k] == 6'(i), "R4",
            {log_hart[k], log_guest[k]}, {14'(i * 5), 6'(i)});
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R6 watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int start;
        logic [13:0] h0;
        logic [10:0] i0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        tgt_ridx = IDXW'(1);
        cyc(1);
        chk(!msg_valid, "R1 valid", 32'(msg_valid), 0);
        chk(pend_clr == '0, "R1 clr", 32'(pend_clr), 0);
        chk(gen_q == '0 && tgt_rdata == '0, "R1 regs", gen_q | tgt_rdata, 0);

        // R5: program targets with bit 11 set; it must read back cleared
        for (int i = 1; i <= NSRC; i++) write_tgt(i, tgt_word(i));
        write_tgt(0, 32'hDEAD_BEEF);
        write_tgt(NSRC + 1, 32'hDEAD_BEEF);
        cyc(20);
        for (int i = 1; i <= NSRC; i++) begin
            tgt_ridx = IDXW'(i);
            cyc(1);
            chk(tgt_rdata == (tgt_word(i) & 32'hFFFF_F7FF), "R5 readback",
                tgt_rdata, tgt_word(i) & 32'hFFFF_F7FF);
        end
        chk(log_n == 0, "R2 no messages without pending", log_n, 0);

        // R2/R6: vector table, each run through a register-write sweep
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] exp;
            logic [7:0] pm;
            int k;
            dom_ie = VEC[v][24];
            src_en = VEC[v][23:16];
            pm     = VEC[v][15:8];
            exp    = VEC[v][7:0];
            set_pend(pm);
            start = log_n;
            pulse_reg_wr();
            cyc(40);
            chk(log_n - start == $countones(exp), "R2 count", log_n - start, $countones(exp));
            k = start;
            for (int i = 1; i <= NSRC; i++) begin
                if (exp[i-1] && k < log_n) begin
                    chk_src_msg(k, i, "R6 order");
                    k++;
                end
            end
            chk(pend == (pm & ~exp), "R3 pending left", 32'(pend), 32'(pm & ~exp));
            // R2: pending kept while the domain was off, delivered later
            if (!VEC[v][24]) begin
                dom_ie = 1'b1;
                start = log_n;
                pulse_reg_wr();
                cyc(40);
                chk(log_n - start == NSRC && pend == '0, "R2 late delivery", log_n - start, NSRC);
            end
            drop_pend();
        end

        // R9/R3: stall with two sources pending, generate request arrives meanwhile
        dom_ie = 1'b1;
        src_en = '1;
        msg_ready = 1'b0;
        set_pend(sb(2) | sb(3));
        start = log_n;
        pulse_reg_wr();
        cyc(10);
        chk(msg_valid && msg_id == 11'h42, "R9 held message", 32'(msg_id), 32'h42);
        chk(pend_clr == '0 && pend == (sb(2) | sb(3)), "R9 no clear while stalled", 32'(pend), 32'(sb(2) | sb(3)));
        h0 = msg_hart;
        i0 = msg_id;
        write_gen(32'hFFFF_FFFF);
        cyc(5);
        chk(msg_valid && msg_hart == h0 && msg_id == i0, "R9 stable fields", 32'(msg_id), 32'(i0));
        chk(gen_q == 32'hFFFC_0FFF, "R8 stored copy", gen_q, 32'hFFFC_0FFF);
        msg_ready = 1'b1;
        cyc(30);
        chk(log_n - start == 3, "R10 count", log_n - start, 3);
        chk_src_msg(start, 2, "R9 first");
        chk(log_id[start+1] == 11'h7FF && log_hart[start+1] == 14'h3FFF && log_guest[start+1] == 6'd0,
            "R10 generated second", 32'(log_id[start+1]), 32'h7FF);
        chk_src_msg(start + 2, 3, "R10 sweep after");
        chk(pend == '0, "R3 both cleared", 32'(pend), 0);

        // R8: generated message goes out with the domain off
        dom_ie = 1'b0;
        start = log_n;
        write_gen(32'h0004_5123);
        cyc(10);
        chk(log_n - start == 1, "R8 one message", log_n - start, 1);
        chk(log_hart[start] == 14'd1 && log_guest[start] == 6'd0 && log_id[start] == 11'h123,
            "R8 fields", {log_hart[start], log_guest[start], log_id[start]}, {14'd1, 6'd0, 11'h123});
        chk(gen_q == 32'h0004_0123, "R8 stored copy", gen_q, 32'h0004_0123);

        // R7: line event evaluates one source only
        dom_ie = 1'b1;
        set_pend(sb(6) | sb(7));
        start = log_n;
        cyc(5);
        chk(log_n == start, "R7 nothing without event", log_n - start, 0);
        line_pulse(6);
        cyc(10);
        chk(log_n - start == 1 && log_id[start] == 11'h46, "R7 single source", 32'(log_id[start]), 32'h46);
        chk(pend == sb(7), "R7 other kept", 32'(pend), 32'(sb(7)));
        line_pulse(0);
        cyc(10);
        chk(log_n - start == 1 && pend == sb(7), "R7 index zero ignored", log_n - start, 1);
        drop_pend();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule